// File: doc/BRIEF.md
# Mailbox Data Object Exchange Controller

This block lets a host move variable-length data objects to and from a device through a narrow window of 32-bit registers. The host pushes a request into a request buffer one word at a time and then sets the go bit. The controller then hands the request to a protocol responder that sits beside it. The responder reads the request and writes its answer into a response buffer. It then reports done with an accept or reject flag and a response length. After an accepted answer the host sees a ready flag. It pulls the answer out one word at a time: it reads the read mailbox, then writes that register to step to the next word.

Errors and aborts are handled inside the block. Stepping past the end of the answer raises a sticky error. That error blanks mailbox reads and blocks new requests until the host aborts. A rejected request is dropped quietly. An optional one-cycle interrupt pulse marks ready or error becoming set, gated by a support parameter, an enable bit and an interrupt status bit that software clears by writing 1 to it.

The sequencer has three states. `ST_IDLE` collects request words. It goes to `ST_BUSY` on go when no error is pending. `ST_BUSY` waits for the responder: done with accept leads to `ST_READY`, done with reject leads back to `ST_IDLE`. `ST_READY` holds the answer and returns to `ST_IDLE` once the last word has been stepped past. An abort sends every state to `ST_IDLE`.

Top module: `mbox_xchg_ctrl`

## Requirements
- R1: After reset the status register (offset 0x0C) and control register (0x08) read 0, and neither `irq_pulse` nor `rsp_start` is asserted.
- R2: Offset 0x04 reads the interrupt-support parameter at bit 0 and the 11-bit message number at bits 11:1. Offset 0x08 reads the interrupt enable at bit 1, and bits 0 (abort) and 31 (go) always read 0. Offsets 0x00 and 0x10 read 0.
- R3: Each write to offset 0x10 stores the word at the current request length and increments that length. A write made when DEPTH words are already held is dropped, and the request length never exceeds DEPTH.
- R4: A read of offset 0x14 returns the response word at the read index when ready is set and error is clear, and returns 0 otherwise.
- R5: A write of any value to offset 0x14 steps the read index. When the new index equals the response length, ready clears and both buffers and all pointers reset, so the next request starts again at word 0.
- R6: Writing bit 31 (go) of the control register in `ST_IDLE` with error clear produces a one-cycle `rsp_start` and presents the request length on `req_len`. Status bit 0 (busy) then reads 1 until the responder's done pulse.
- R7: Done with accept sets status bit 31 (ready) and holds the response length, clamped to DEPTH. Done with reject sets neither ready nor error and empties the request buffer.
- R8: Stepping the read index past the response length (from `ST_IDLE` the length counts as 0) sets status bit 2 (error). Error stays set until abort, and go is ignored while it is set.
- R9: A control write with bit 0 (abort) set clears ready, error and busy and resets both buffers and pointers. The go and interrupt-enable bits of that same write are ignored.
- R10: `irq_pulse` is a one-cycle pulse, in the cycle the status shows ready or error newly set, that also sets status bit 1. It occurs only when interrupts are supported and enabled and status bit 1 was 0. Writing 1 to status bit 1 clears it.
- R11: A control write without abort loads the interrupt enable from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset within the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| rsp_start | output | 1 | One-cycle request hand-off to the responder |
| req_len | output | CNT_W | Number of request words held |
| req_rd_addr | input | IDX_W | Responder read index into the request buffer |
| req_rd_data | output | 32 | Request word at `req_rd_addr` |
| resp_wr_en | input | 1 | Responder write strobe into the response buffer (taken only while busy) |
| resp_wr_addr | input | IDX_W | Response buffer write index |
| resp_wr_data | input | 32 | Response word |
| rsp_done | input | 1 | Responder finished |
| rsp_accept | input | 1 | With done: 1 accepts, 0 rejects |
| rsp_len | input | CNT_W | With done: response length in words |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
A wrong pointer or state shows at the ports within one register access. A read index that is off by one returns the wrong mailbox word on the next read. A missed drain leaves ready set after the last step. A stuck sequencer is visible either as a missing `rsp_start` one cycle after go or as busy that never clears. A fault in the interrupt status logic shows in the cycle after the causing edge, as a missing or doubled `irq_pulse`. That pulse is compared on every clock against a model that knows which write or done pulse should raise it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    // register window byte offsets
    localparam logic [7:0] OFS_CAP  = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_STAT = 8'h0C;
    localparam logic [7:0] OFS_WMB  = 8'h10;
    localparam logic [7:0] OFS_RMB  = 8'h14;

    // control bit positions
    localparam int CTL_ABORT = 0;
    localparam int CTL_IEN   = 1;
    localparam int CTL_GO    = 31;

    // status bit positions
    localparam int STS_BUSY = 0;
    localparam int STS_INT  = 1;
    localparam int STS_ERR  = 2;
    localparam int STS_RDY  = 31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2
    } xchg_state_t;

    // decoded host write strobes
    typedef struct packed {
        logic ctrl;
        logic stat;
        logic wmb;
        logic rmb;
    } host_wr_t;

endpackage

// File: rtl/mbox_buf.sv
module mbox_buf #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
    parameter int INTR_SUPP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ien,
    input  logic raise,
    input  logic clear,
    output logic intr_sts,
    output logic irq_pulse
);

    generate
        if (INTR_SUPP != 0) begin : g_irq
            logic fire;

            always_comb begin
                fire = raise && ien && !intr_sts;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    intr_sts  <= 1'b0;
                    irq_pulse <= 1'b0;
                end else begin
                    irq_pulse <= fire;
                    if (fire) begin
                        intr_sts <= 1'b1;
                    end else if (clear) begin
                        intr_sts <= 1'b0;
                    end
                end
            end
        end else begin : g_noirq
            logic unused_in;

            assign unused_in = &{1'b0, ien, raise, clear, clk, rst_n};
            assign intr_sts  = 1'b0;
            assign irq_pulse = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  host_wr_t         hw,
    input  logic             abort_bit,
    input  logic             go_bit,
    input  logic             ien_bit,
    input  logic             rsp_done,
    input  logic             rsp_accept,
    input  logic [CNT_W-1:0] rsp_len,
    output xchg_state_t      state,
    output logic             err,
    output logic             ien,
    output logic             start_pulse,
    output logic             ready_set,
    output logic             err_set,
    output logic [CNT_W-1:0] wr_len,
    output logic [CNT_W-1:0] resp_len_q,
    output logic [PTR_W-1:0] rd_idx,
    output logic             req_we,
    output logic [IDX_W-1:0] req_waddr
);

    xchg_state_t      nxt;
    logic             abort_req;
    logic             go_req;
    logic             adv;
    logic             drained;
    logic             overrun;
    logic             done_ok;
    logic             done_bad;
    logic             flush;
    logic [PTR_W-1:0] rd_next;
    logic [PTR_W-1:0] lim;
    logic [CNT_W-1:0] len_clamped;

    // event decode
    always_comb begin
        abort_req   = hw.ctrl && abort_bit;
        go_req      = hw.ctrl && !abort_bit && go_bit;
        adv         = hw.rmb && !err && (state != ST_BUSY);
        rd_next     = rd_idx + 1'b1;
        lim         = (state == ST_READY) ? PTR_W'(resp_len_q) : '0;
        drained     = adv && (state == ST_READY) && (rd_next == lim);
        overrun     = adv && (rd_next > lim);
        done_ok     = (state == ST_BUSY) && rsp_done && rsp_accept && !abort_req;
        done_bad    = (state == ST_BUSY) && rsp_done && !rsp_accept && !abort_req;
        flush       = abort_req || drained || done_bad;
        req_we      = hw.wmb && (state != ST_BUSY) && (wr_len < CNT_W'(DEPTH));
        req_waddr   = wr_len[IDX_W-1:0];
        len_clamped = (rsp_len > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : rsp_len;
        ready_set   = done_ok;
        err_set     = overrun;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (go_req && !err) begin
                    nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (done_ok) begin
                    nxt = ST_READY;
                end else if (done_bad) begin
                    nxt = ST_IDLE;
                end
            end
            ST_READY: begin
                if (drained) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        if (abort_req) begin
            nxt = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err         <= 1'b0;
            ien         <= 1'b0;
            start_pulse <= 1'b0;
            wr_len      <= '0;
            rd_idx      <= '0;
            resp_len_q  <= '0;
        end else begin
            start_pulse <= (state == ST_IDLE) && (nxt == ST_BUSY);

            if (abort_req) begin
                err <= 1'b0;
            end else if (overrun) begin
                err <= 1'b1;
            end

            if (hw.ctrl && !abort_bit) begin
                ien <= ien_bit;
            end

            if (flush) begin
                wr_len <= '0;
            end else if (req_we) begin
                wr_len <= wr_len + 1'b1;
            end

            if (flush) begin
                rd_idx <= '0;
            end else if (adv && !overrun) begin
                rd_idx <= rd_next;
            end

            if (flush) begin
                resp_len_q <= '0;
            end else if (done_ok) begin
                resp_len_q <= len_clamped;
            end
        end
    end

endmodule

// File: rtl/mbox_xchg_ctrl.sv
module mbox_xchg_ctrl
    import mbox_pkg::*;
#(
    parameter int          DEPTH     = 64,
    parameter int          INTR_SUPP = 1,
    parameter logic [10:0] INTR_MSG  = 11'h2A5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             rsp_start,
    output logic [CNT_W-1:0] req_len,
    input  logic [IDX_W-1:0] req_rd_addr,
    output logic [31:0]      req_rd_data,
    input  logic             resp_wr_en,
    input  logic [IDX_W-1:0] resp_wr_addr,
    input  logic [31:0]      resp_wr_data,
    input  logic             rsp_done,
    input  logic             rsp_accept,
    input  logic [CNT_W-1:0] rsp_len,
    output logic             irq_pulse
);

    host_wr_t         hw;
    xchg_state_t      state;
    logic             st_ready;
    logic             st_busy;
    logic             st_err;
    logic             ien;
    logic             intr_sts;
    logic             abort_wr;
    logic             start_pulse;
    logic             ready_set;
    logic             err_set;
    logic [CNT_W-1:0] wr_len;
    logic [CNT_W-1:0] resp_len_q;
    logic [PTR_W-1:0] rd_idx;
    logic             req_we;
    logic [IDX_W-1:0] req_waddr;
    logic             resp_we;
    logic [31:0]      resp_rdata;

    // address decode
    always_comb begin
        hw.ctrl  = reg_wr_en && (reg_addr == OFS_CTRL);
        hw.stat  = reg_wr_en && (reg_addr == OFS_STAT);
        hw.wmb   = reg_wr_en && (reg_addr == OFS_WMB);
        hw.rmb   = reg_wr_en && (reg_addr == OFS_RMB);
        abort_wr = hw.ctrl && reg_wdata[CTL_ABORT];
    end

    mbox_seq #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw         (hw),
        .abort_bit  (reg_wdata[CTL_ABORT]),
        .go_bit     (reg_wdata[CTL_GO]),
        .ien_bit    (reg_wdata[CTL_IEN]),
        .rsp_done   (rsp_done),
        .rsp_accept (rsp_accept),
        .rsp_len    (rsp_len),
        .state      (state),
        .err        (st_err),
        .ien        (ien),
        .start_pulse(start_pulse),
        .ready_set  (ready_set),
        .err_set    (err_set),
        .wr_len     (wr_len),
        .resp_len_q (resp_len_q),
        .rd_idx     (rd_idx),
        .req_we     (req_we),
        .req_waddr  (req_waddr)
    );

    mbox_irq #(.INTR_SUPP(INTR_SUPP)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien      (ien),
        .raise    (ready_set || err_set),
        .clear    (hw.stat && reg_wdata[STS_INT]),
        .intr_sts (intr_sts),
        .irq_pulse(irq_pulse)
    );

    // request buffer: host writes, responder reads
    mbox_buf #(.DEPTH(DEPTH), .WIDTH(32)) u_req_buf (
        .clk  (clk),
        .we   (req_we),
        .waddr(req_waddr),
        .wdata(reg_wdata),
        .raddr(req_rd_addr),
        .rdata(req_rd_data)
    );

    // response buffer: responder writes while busy, host reads
    assign resp_we = resp_wr_en && st_busy;

    mbox_buf #(.DEPTH(DEPTH), .WIDTH(32)) u_resp_buf (
        .clk  (clk),
        .we   (resp_we),
        .waddr(resp_wr_addr),
        .wdata(resp_wr_data),
        .raddr(rd_idx[IDX_W-1:0]),
        .rdata(resp_rdata)
    );

    assign st_ready  = (state == ST_READY);
    assign st_busy   = (state == ST_BUSY);
    assign rsp_start = start_pulse;
    assign req_len   = wr_len;

    // register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CAP: begin
                reg_rdata[0]    = (INTR_SUPP != 0);
                reg_rdata[11:1] = INTR_MSG;
            end
            OFS_CTRL: begin
                reg_rdata[CTL_IEN] = ien;
            end
            OFS_STAT: begin
                reg_rdata[STS_BUSY] = st_busy;
                reg_rdata[STS_INT]  = intr_sts;
                reg_rdata[STS_ERR]  = st_err;
                reg_rdata[STS_RDY]  = st_ready;
            end
            OFS_RMB: begin
                if (st_ready && !st_err) begin
                    reg_rdata = resp_rdata;
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    // resp_len_q feeds the sequencer compare; keep it visible for the checker
    logic unused_len;
    assign unused_len = ^resp_len_q;

endmodule

// File: rtl/mbox_xchg_chk.sv
module mbox_xchg_chk
    import mbox_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int INTR_SUPP = 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             abort_wr,
    input logic             rsp_start,
    input logic             irq_pulse,
    input logic             st_ready,
    input logic             st_busy,
    input logic             st_err,
    input logic             ien,
    input logic             intr_sts,
    input logic [CNT_W-1:0] wr_len
);

    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_len <= CNT_W'(DEPTH));

    // R4
    a_r4_rmb_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_RMB && !(st_ready && !st_err)) |-> (reg_rdata == 32'h0));

    // R6
    a_r6_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_start |-> st_busy);

    // R6
    a_r6_busy_has_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_busy) |-> rsp_start);

    // R8
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_err && !abort_wr) |=> st_err);

    // R9
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> (!st_ready && !st_err && !st_busy));

    // R10
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (ien && INTR_SUPP != 0));

    // R10
    a_r10_irq_once: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (intr_sts && !$past(intr_sts)));

endmodule

bind mbox_xchg_ctrl mbox_xchg_chk #(.DEPTH(DEPTH), .INTR_SUPP(INTR_SUPP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .abort_wr (abort_wr),
    .rsp_start(rsp_start),
    .irq_pulse(irq_pulse),
    .st_ready (st_ready),
    .st_busy  (st_busy),
    .st_err   (st_err),
    .ien      (ien),
    .intr_sts (intr_sts),
    .wr_len   (wr_len)
);

// File: tb/sim_mbox_xchg_ctrl.sv
`timescale 1ns/1ps
module sim_mbox_xchg_ctrl;

    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [7:0] A_CAP  = 8'h04;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_WMB  = 8'h10;
    localparam logic [7:0] A_RMB  = 8'h14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic [7:0]       reg_addr = 8'h0C;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             rsp_start;
    logic [CNT_W-1:0] req_len;
    logic [IDX_W-1:0] req_rd_addr = '0;
    logic [31:0]      req_rd_data;
    logic             resp_wr_en = 1'b0;
    logic [IDX_W-1:0] resp_wr_addr = '0;
    logic [31:0]      resp_wr_data = '0;
    logic             rsp_done = 1'b0;
    logic             rsp_accept = 1'b0;
    logic [CNT_W-1:0] rsp_len = '0;
    logic             irq_pulse;

    always #5 clk = ~clk;

    mbox_xchg_ctrl #(.DEPTH(DEPTH), .INTR_SUPP(1), .INTR_MSG(11'h2A5)) u0 (.*);

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;

    // behavioural reference state
    bit          m_ready, m_err, m_busy, m_intr, m_ien;
    logic [31:0] m_wq[$];
    logic [31:0] m_rq[$];
    int          m_ridx;
    bit          exp_irq = 0;
    bit          exp_start = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] stat_exp();
        return {m_ready, 28'b0, m_err, m_intr, m_busy};
    endfunction

    task automatic m_flush();
        m_wq.delete();
        m_rq.delete();
        m_ridx = 0;
    endtask

    task automatic m_raise();
        if (m_ien && !m_intr) begin
            m_intr  = 1;
            exp_irq = 1;
        end
    endtask

    task automatic m_apply(input logic [7:0] a, input logic [31:0] d);
        case (a)
            A_CTRL: begin
                if (d[0]) begin
                    m_ready = 0; m_err = 0; m_busy = 0;
                    m_flush();
                end else begin
                    if (d[31] && !m_err && !m_ready && !m_busy) begin
                        m_busy    = 1;
                        exp_start = 1;
                    end
                    m_ien = d[1];
                end
            end
            A_STAT: if (d[1]) m_intr = 0;
            A_WMB:  if (!m_busy && m_wq.size() < DEPTH) m_wq.push_back(d);
            A_RMB: begin
                if (!m_busy && !m_err) begin
                    m_ridx++;
                    if (m_ready && m_ridx == m_rq.size()) begin
                        m_ready = 0;
                        m_flush();
                    end else if (m_ridx > (m_ready ? m_rq.size() : 0)) begin
                        m_err = 1;
                        m_raise();
                    end
                end
            end
            default: ;
        endcase
    endtask

    // every-clock comparison of the pulse outputs (R6, R10)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            tests++;
            if (irq_pulse !== exp_irq || rsp_start !== exp_start) begin
                fails++;
                $display("FAIL R10/R6 pulses got irq=%0b start=%0b exp irq=%0b start=%0b",
                         irq_pulse, rsp_start, exp_irq, exp_start);
            end
            exp_irq   = 0;
            exp_start = 0;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        m_apply(a, d);
        @(negedge clk);
        reg_wr_en = 0; reg_addr = A_STAT;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_stat(input string tag);
        logic [31:0] v;
        rd(A_STAT, v);
        chk(tag, v, stat_exp());
    endtask

    function automatic logic [31:0] resp_word(input int i);
        return (i < m_wq.size() ? m_wq[i] : 32'h0) ^ 32'h5A00_0000 ^ i;
    endfunction

    // behavioural responder: check request, write answer, report done
    task automatic respond(input bit accept, input int nwait, input int rlen);
        logic [31:0] resp[$];
        #1;
        chk("R6 req_len", 32'(req_len), 32'(m_wq.size()));
        chk_stat("R6 busy while waiting");
        for (int i = 0; i < m_wq.size(); i++) begin
            @(negedge clk);
            req_rd_addr = IDX_W'(i);
            #1;
            chk("R3 request word", req_rd_data, m_wq[i]);
        end
        if (accept) begin
            for (int i = 0; i < rlen; i++) begin
                resp.push_back(resp_word(i));
            end
        end
        for (int i = 0; i < resp.size(); i++) begin
            @(negedge clk);
            resp_wr_en = 1; resp_wr_addr = IDX_W'(i); resp_wr_data = resp[i];
        end
        @(negedge clk);
        resp_wr_en = 0;
        repeat (nwait) @(negedge clk);
        rsp_done = 1; rsp_accept = accept; rsp_len = CNT_W'(rlen);
        @(posedge clk);
        #1;
        m_busy = 0;
        if (accept) begin
            m_ready = 1;
            m_rq    = resp;
            m_ridx  = 0;
            m_raise();
        end else begin
            m_flush();
        end
        @(negedge clk);
        rsp_done = 0;
    endtask

    task automatic drain_one(input string tag);
        logic [31:0] v;
        logic [31:0] e;
        e = (m_ready && !m_err && m_ridx < m_rq.size()) ? m_rq[m_ridx] : 32'h0;
        rd(A_RMB, v);
        chk(tag, v, e);
        wr(A_RMB, 32'hDEAD_0000);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        m_ready = 0; m_err = 0; m_busy = 0; m_intr = 0; m_ien = 0; m_ridx = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(A_STAT, v); chk("R1 status after reset", v, 32'h0);
        rd(A_CTRL, v); chk("R1 control after reset", v, 32'h0);

        // R2 capability and unmapped offsets
        rd(A_CAP, v);  chk("R2 capability", v, (32'h2A5 << 1) | 32'h1);
        rd(8'h00, v);  chk("R2 offset 0", v, 32'h0);
        rd(A_WMB, v);  chk("R2 write mailbox reads zero", v, 32'h0);

        // R11 enable, R2 abort/go read as zero
        wr(A_CTRL, 32'h0000_0002);
        rd(A_CTRL, v); chk("R11 enable set", v, 32'h2);

        // R6/R7/R10 accepted exchange of 3 words
        wr(A_WMB, 32'h1111_0001);
        wr(A_WMB, 32'h2222_0002);
        wr(A_WMB, 32'h3333_0003);
        wr(A_CTRL, 32'h8000_0002);
        rd(A_CTRL, v); chk("R2 go reads zero", v, 32'h2);
        respond(1, 2, 3);
        chk_stat("R7 ready and R10 intr set");
        for (int i = 0; i < 3; i++) drain_one("R4 response word");
        chk_stat("R5 ready cleared after last word");

        // R10 no second pulse while status bit 1 set
        wr(A_WMB, 32'hABCD_0001);
        wr(A_CTRL, 32'h8000_0002);
        respond(1, 1, 1);
        chk_stat("R10 no re-raise");
        drain_one("R5 fresh index");
        wr(A_STAT, 32'h0000_0002);
        chk_stat("R10 W1C clears");

        // R7 reject empties request buffer
        wr(A_WMB, 32'h0BAD_0001);
        wr(A_WMB, 32'h0BAD_0002);
        wr(A_CTRL, 32'h8000_0002);
        respond(0, 0, 0);
        chk_stat("R7 reject silent");
        wr(A_WMB, 32'h600D_0001);
        wr(A_CTRL, 32'h8000_0002);
        respond(1, 0, 1);
        drain_one("R7 after reject");
        wr(A_STAT, 32'h0000_0002);

        // R8 overrun from idle, go blocked, R10 pulse on error
        wr(A_RMB, 32'h0);
        chk_stat("R8 error set");
        rd(A_RMB, v); chk("R8 read blanked", v, 32'h0);
        wr(A_WMB, 32'h7777_0001);
        wr(A_CTRL, 32'h8000_0002);
        chk_stat("R8 go ignored");

        // R9 abort ignores go and enable bits of same write
        wr(A_CTRL, 32'h8000_0001);
        chk_stat("R9 abort clears");
        rd(A_CTRL, v); chk("R9 enable untouched", v, 32'h2);
        wr(A_STAT, 32'h0000_0002);

        // R4/R8 ready with zero-length answer then overrun
        wr(A_WMB, 32'h4444_0001);
        wr(A_CTRL, 32'h8000_0002);
        respond(1, 1, 0);
        wr(A_RMB, 32'h0);
        chk_stat("R8 ready and error");
        rd(A_RMB, v); chk("R4 blank with error", v, 32'h0);
        wr(A_CTRL, 32'h0000_0003);
        chk_stat("R9 abort after error");
        wr(A_STAT, 32'h0000_0002);

        // R3 full request buffer drops extra word
        for (int i = 0; i <= DEPTH; i++) wr(A_WMB, 32'hF000_0000 + i);
        wr(A_CTRL, 32'h8000_0002);
        respond(1, 0, DEPTH);
        chk("R3 length capped", 32'(m_wq.size()), DEPTH);
        drain_one("R4 big answer word 0");
        drain_one("R4 big answer word 1");
        wr(A_CTRL, 32'h0000_0001);
        chk_stat("R9 abort mid drain");
        rd(A_CTRL, v); chk("R9 ctrl after abort", v, 32'h2);

        // R11 disabled: no pulse, no status
        wr(A_CTRL, 32'h0000_0000);
        wr(A_WMB, 32'h5555_0001);
        wr(A_CTRL, 32'h8000_0000);
        respond(1, 1, 1);
        chk_stat("R11 disabled no intr");
        drain_one("R4 disabled answer");
        chk_stat("R5 idle at end");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule